// File: doc/BRIEF.md
# Microcontroller GPIO Port Bank

This block holds the memory-mapped I/O ports of a small 8-bit microcontroller. It has a parameterised number of bidirectional ports. Each of these ports has a direction (configuration) register, an output data register and a registered sample of its pin levels. It also has one output-only port and one input-only port. The CPU reaches every register through a plain 8-bit address, 8-bit write-data and write-enable bus. Read data comes back combinationally for the address presented.

The last bidirectional port carries two dedicated functions. Bit 1 is always driven by the watchdog/clock-monitor error signal, even while reset is asserted. Bit 7 either drives the oscillator clock or acts as a plain input, and its configuration bit selects which. The output-only port is forced to all ones during reset. Its pins are re-registered, so they follow the register one clock later than the other ports. The input-only port has no registers and is read directly from its pins. On the default reduced-pin build its absent bits read as zero.

Pads are modelled as split signals: output enable, output value and weak pull-up enable per bit, with a separate input level.

Top module: `gpio_bank`

## Requirements
- R1: While reset is low and right after it, every data and configuration register of the bidirectional ports reads 0x00, and every bidirectional pad has output enable 0 and pull-up 0, except bit 1 of the last port.
- R2: For an ordinary bidirectional bit, the pad output enable equals its configuration bit and the pad output value equals its data bit.
- R3: For an ordinary bidirectional bit with configuration 0, the pull-up enable equals the data bit. With configuration 1 the pull-up is 0, so output enable and pull-up are never both 1.
- R4: Reading the pin address of a port returns the pin levels sampled at the previous rising clock edge. A pin change is not visible before that edge.
- R5: The output-only port pins are 0xFF at any time reset is low, asynchronously, and its register reads 0xFF after reset.
- R6: A write to the output-only port is readable at its address after the write edge, but its pins change one clock edge later.
- R7: Bit 1 of the last bidirectional port always has output enable 1, pull-up 0 and output value equal to the watchdog error input, during and after reset. Writes to its data or configuration bit 1 do not change the pad.
- R8: Bit 7 of the last bidirectional port drives the oscillator clock input with output enable 1 when its configuration bit is 1. When that bit is 0 it has output enable 0 and pull-up 0 regardless of its data bit.
- R9: Reading the input-only port returns its pin levels AND the present-bit mask (default 0x3F), so absent bits read 0. Writes to it have no effect.
- R10: Any address that is not a data, configuration or pin address of a bidirectional port, nor the output or input port address, reads 0x00. Writes to such addresses, and to pin addresses, change no register.
- R11: Address map: port k has its data register at BASE+4k, its configuration register at BASE+4k+1 and its pin read at BASE+4k+2 (BASE default 0xD0). The output port is at 0xDC and the input port at 0xDD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| bd_pin_in | input | NUM_BIDIR*8 | Pin levels of the bidirectional ports, port k at bits 8k+7..8k |
| bd_pin_out | output | NUM_BIDIR*8 | Pad output values |
| bd_pin_oe | output | NUM_BIDIR*8 | Pad output enables |
| bd_pin_pu | output | NUM_BIDIR*8 | Weak pull-up enables |
| wd_err | input | 1 | Watchdog/clock-monitor error level for the dedicated pin |
| osc_clk | input | 1 | Oscillator clock level for the clock-output pin |
| out_pins | output | 8 | Output-only port pins |
| in_pins | input | 8 | Input-only port pins |

## Verification
The assertions watch several properties on every cycle. The dedicated watchdog pin stays driven and tracks its input. The clock-output pin never enables a pull-up and carries the oscillator level whenever it is enabled. No pad ever drives and pulls up at once. The output-only pins equal the previous cycle's register value, and they are all ones whenever reset is low. Absent input bits and unmapped addresses read zero. The bench's sweeps cover everything that depends on what was written or applied earlier: the full configuration/data decode per bit, register readback, the one-edge lag of pin sampling, the ignored writes to dedicated bits and unmapped addresses, and the asynchronous preset of the output port in the middle of a run.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int ADDR_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;

  // offset of each register inside a bidirectional port's 4-byte slot
  typedef enum logic [1:0] {
    SLOT_DATA = 2'd0,
    SLOT_CFG  = 2'd1,
    SLOT_PIN  = 2'd2,
    SLOT_RSVD = 2'd3
  } slot_e;

  typedef struct packed {
    logic oe;
    logic out;
    logic pu;
  } pad_ctl_t;

  // register address of one slot of bidirectional port idx
  function automatic addr_t port_addr(addr_t base, int unsigned idx, slot_e slot);
    return base + addr_t'(idx * 4) + addr_t'(slot);
  endfunction

  // pad control from a configuration bit and a data bit
  function automatic pad_ctl_t pad_from_regs(logic cfg_bit, logic dat_bit);
    pad_ctl_t p;
    p.oe  = cfg_bit;
    p.out = dat_bit;
    p.pu  = ~cfg_bit & dat_bit;
    return p;
  endfunction

  // true for every address that returns a register value
  function automatic logic addr_mapped(addr_t a, addr_t base, int unsigned nb,
                                       addr_t out_a, addr_t in_a);
    logic hit;
    hit = (a == out_a) || (a == in_a);
    for (int unsigned k = 0; k < nb; k++) begin
      if (a == port_addr(base, k, SLOT_DATA) || a == port_addr(base, k, SLOT_CFG) ||
          a == port_addr(base, k, SLOT_PIN))
        hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/gpio_bidir_port.sv
module gpio_bidir_port
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic         wr_cfg,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] alt_en,
  input  logic [W-1:0] alt_oe,
  input  logic [W-1:0] alt_out,
  output logic [W-1:0] data_q,
  output logic [W-1:0] cfg_q,
  output logic [W-1:0] pin_q,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cfg_q  <= '0;
      pin_q  <= '0;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_cfg)  cfg_q  <= wdata;
      pin_q <= pin_in;
    end
  end

  // per-bit pad control; a dedicated function overrides the register path
  for (genvar b = 0; b < W; b++) begin : g_bit
    pad_ctl_t gp;
    assign gp         = pad_from_regs(cfg_q[b], data_q[b]);
    assign pad_oe[b]  = alt_en[b] ? alt_oe[b]  : gp.oe;
    assign pad_out[b] = alt_en[b] ? alt_out[b] : gp.out;
    assign pad_pu[b]  = alt_en[b] ? 1'b0       : gp.pu;
  end

endmodule

// File: rtl/gpio_out_port.sv
module gpio_out_port #(
  parameter int           W      = 8,
  parameter logic [W-1:0] PRESET = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] reg_q,
  output logic [W-1:0] pins
);

  // register stage, then a retiming stage that puts the pins one clock behind
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= PRESET;
      pins  <= PRESET;
    end else begin
      if (wr_en) reg_q <= wdata;
      pins <= reg_q;
    end
  end

endmodule

// File: rtl/gpio_in_port.sv
module gpio_in_port #(
  parameter int           W       = 8,
  parameter logic [W-1:0] PRESENT = '1
) (
  input  logic [W-1:0] pins,
  output logic [W-1:0] rd_val
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (PRESENT[b]) begin : g_present
      assign rd_val[b] = pins[b];
    end else begin : g_absent
      assign rd_val[b] = 1'b0;
    end
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int          NUM_BIDIR  = 3,
  parameter int          W          = 8,
  parameter logic [7:0]  BASE_ADDR  = 8'hD0,
  parameter logic [7:0]  OUT_ADDR   = 8'hDC,
  parameter logic [7:0]  IN_ADDR    = 8'hDD,
  parameter logic [7:0]  IN_PRESENT = 8'h3F,
  parameter int          SPEC_PORT  = NUM_BIDIR - 1,
  parameter int          WD_BIT     = 1,
  parameter int          CLK_BIT    = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             bus_addr,
  input  logic                   bus_we,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  input  logic [NUM_BIDIR*W-1:0] bd_pin_in,
  output logic [NUM_BIDIR*W-1:0] bd_pin_out,
  output logic [NUM_BIDIR*W-1:0] bd_pin_oe,
  output logic [NUM_BIDIR*W-1:0] bd_pin_pu,
  input  logic                   wd_err,
  input  logic                   osc_clk,
  output logic [7:0]             out_pins,
  input  logic [7:0]             in_pins
);

  localparam int BW = NUM_BIDIR * W;

  logic [W-1:0] port_data [NUM_BIDIR];
  logic [W-1:0] port_cfg  [NUM_BIDIR];
  logic [W-1:0] port_pin  [NUM_BIDIR];

  // named internal events, brought out for the checker
  logic [NUM_BIDIR-1:0] wr_data_hit;
  logic [NUM_BIDIR-1:0] wr_cfg_hit;
  logic                 wr_out_hit;
  logic [7:0]           out_reg_q;
  logic [7:0]           in_val;

  for (genvar k = 0; k < NUM_BIDIR; k++) begin : g_port
    logic [W-1:0] alt_en;
    logic [W-1:0] alt_oe;
    logic [W-1:0] alt_out;

    assign wr_data_hit[k] = bus_we && (bus_addr == port_addr(BASE_ADDR, k, SLOT_DATA));
    assign wr_cfg_hit[k]  = bus_we && (bus_addr == port_addr(BASE_ADDR, k, SLOT_CFG));

    for (genvar b = 0; b < W; b++) begin : g_alt
      if (k == SPEC_PORT && b == WD_BIT) begin : g_wd
        assign alt_en[b]  = 1'b1;
        assign alt_oe[b]  = 1'b1;
        assign alt_out[b] = wd_err;
      end else if (k == SPEC_PORT && b == CLK_BIT) begin : g_ck
        assign alt_en[b]  = 1'b1;
        assign alt_oe[b]  = port_cfg[k][b];
        assign alt_out[b] = osc_clk;
      end else begin : g_gp
        assign alt_en[b]  = 1'b0;
        assign alt_oe[b]  = 1'b0;
        assign alt_out[b] = 1'b0;
      end
    end

    gpio_bidir_port #(.W(W)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_data (wr_data_hit[k]),
      .wr_cfg  (wr_cfg_hit[k]),
      .wdata   (bus_wdata[W-1:0]),
      .pin_in  (bd_pin_in[k*W +: W]),
      .alt_en  (alt_en),
      .alt_oe  (alt_oe),
      .alt_out (alt_out),
      .data_q  (port_data[k]),
      .cfg_q   (port_cfg[k]),
      .pin_q   (port_pin[k]),
      .pad_oe  (bd_pin_oe[k*W +: W]),
      .pad_out (bd_pin_out[k*W +: W]),
      .pad_pu  (bd_pin_pu[k*W +: W])
    );
  end

  assign wr_out_hit = bus_we && (bus_addr == OUT_ADDR);

  gpio_out_port #(.W(8), .PRESET(8'hFF)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_out_hit),
    .wdata (bus_wdata),
    .reg_q (out_reg_q),
    .pins  (out_pins)
  );

  gpio_in_port #(.W(8), .PRESENT(IN_PRESENT)) u_in (
    .pins   (in_pins),
    .rd_val (in_val)
  );

  // read multiplexer
  always_comb begin
    bus_rdata = '0;
    for (int unsigned k = 0; k < NUM_BIDIR; k++) begin
      if (bus_addr == port_addr(BASE_ADDR, k, SLOT_DATA)) bus_rdata = 8'(port_data[k]);
      if (bus_addr == port_addr(BASE_ADDR, k, SLOT_CFG))  bus_rdata = 8'(port_cfg[k]);
      if (bus_addr == port_addr(BASE_ADDR, k, SLOT_PIN))  bus_rdata = 8'(port_pin[k]);
    end
    if (bus_addr == OUT_ADDR) bus_rdata = out_reg_q;
    if (bus_addr == IN_ADDR)  bus_rdata = in_val;
  end

  localparam int UNUSED_BW = BW;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_pkg::*;
#(
  parameter int         NB         = 3,
  parameter int         W          = 8,
  parameter logic [7:0] BASE_ADDR  = 8'hD0,
  parameter logic [7:0] OUT_ADDR   = 8'hDC,
  parameter logic [7:0] IN_ADDR    = 8'hDD,
  parameter logic [7:0] IN_PRESENT = 8'h3F,
  parameter int         SPEC_PORT  = NB - 1,
  parameter int         WD_BIT     = 1,
  parameter int         CLK_BIT    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    bus_addr,
  input logic [7:0]    bus_rdata,
  input logic [NB*W-1:0] bd_pin_out,
  input logic [NB*W-1:0] bd_pin_oe,
  input logic [NB*W-1:0] bd_pin_pu,
  input logic          wd_err,
  input logic          osc_clk,
  input logic [7:0]    out_pins,
  input logic [7:0]    out_reg_q
);

  localparam int WDI = SPEC_PORT * W + WD_BIT;
  localparam int CKI = SPEC_PORT * W + CLK_BIT;

  assert_wd_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bd_pin_oe[WDI] && !bd_pin_pu[WDI] && (bd_pin_out[WDI] == wd_err));

  assert_no_contention_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bd_pin_oe & bd_pin_pu) == '0);

  assert_out_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_pins == $past(out_reg_q));

  assert_clk_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bd_pin_oe[CKI] |-> (bd_pin_out[CKI] == osc_clk));

  assert_clk_nopull_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bd_pin_pu[CKI]);

  assert_in_absent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == IN_ADDR) |-> ((bus_rdata & ~IN_PRESENT) == 8'h00));

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_mapped(bus_addr, BASE_ADDR, NB, OUT_ADDR, IN_ADDR) |-> (bus_rdata == 8'h00));

  // reset-time behaviour, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      assert_out_preset_R5: assert (out_pins == 8'hFF);
      assert_wd_in_reset_R7: assert (bd_pin_oe[WDI] && (bd_pin_out[WDI] == wd_err));
    end
  end

endmodule

bind gpio_bank gpio_bank_chk #(
  .NB(NUM_BIDIR), .W(W), .BASE_ADDR(BASE_ADDR), .OUT_ADDR(OUT_ADDR),
  .IN_ADDR(IN_ADDR), .IN_PRESENT(IN_PRESENT), .SPEC_PORT(SPEC_PORT),
  .WD_BIT(WD_BIT), .CLK_BIT(CLK_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .bd_pin_out(bd_pin_out), .bd_pin_oe(bd_pin_oe), .bd_pin_pu(bd_pin_pu),
  .wd_err(wd_err), .osc_clk(osc_clk), .out_pins(out_pins), .out_reg_q(out_reg_q)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam logic [7:0] BASE = 8'hD0;
  localparam logic [7:0] OUTA = 8'hDC;
  localparam logic [7:0] INA  = 8'hDD;
  localparam logic [7:0] INMASK = 8'h3F;

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] bus_addr;
  logic bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [NB*8-1:0] bd_pin_in, bd_pin_out, bd_pin_oe, bd_pin_pu;
  logic wd_err, osc_clk;
  logic [7:0] out_pins, in_pins;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bd_pin_in(bd_pin_in),
    .bd_pin_out(bd_pin_out), .bd_pin_oe(bd_pin_oe), .bd_pin_pu(bd_pin_pu),
    .wd_err(wd_err), .osc_clk(osc_clk), .out_pins(out_pins), .in_pins(in_pins)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [7:0] a_of(int k, int slot);
    return BASE + 8'(k * 4 + slot);
  endfunction

  function automatic bit is_mapped(logic [7:0] a);
    if (a == OUTA || a == INA) return 1;
    if (a >= BASE && a < BASE + 8'(NB * 4) && ((a - BASE) % 4) != 3) return 1;
    return 0;
  endfunction

  // expected {oe, out, pu} for one pad
  function automatic logic [2:0] exp_pad(int k, int b, logic c, logic d, logic wd, logic ck);
    if (k == NB - 1 && b == 1) return {1'b1, wd, 1'b0};
    if (k == NB - 1 && b == 7) return {c, ck, 1'b0};
    return {c, d, ~c & d};
  endfunction

  task automatic finish_test();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_test();
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] prev;
    logic [7:0] cfgs [5] = '{8'h00, 8'hFF, 8'h0F, 8'hA5, 8'h5A};
    logic [NB*8-1:0] eoe, eout, epu;

    rst_n = 1'b0; bus_addr = 8'h00; bus_we = 1'b0; bus_wdata = 8'h00;
    bd_pin_in = '0; wd_err = 1'b0; osc_clk = 1'b0; in_pins = 8'h00;

    // reset state
    @(negedge clk); @(negedge clk);
    chk(out_pins == 8'hFF, "R5 out preset in reset", out_pins, 8'hFF);
    chk(bd_pin_oe == 24'h020000, "R1 oe in reset", bd_pin_oe, 24'h020000);
    chk(bd_pin_pu == '0, "R1 pu in reset", bd_pin_pu, 0);
    chk(bd_pin_out[17] == 1'b0, "R7 wd pin in reset", bd_pin_out[17], 0);
    wd_err = 1'b1; #1;
    chk(bd_pin_out[17] == 1'b1 && bd_pin_oe[17], "R7 wd pin follows in reset", bd_pin_out[17], 1);
    wd_err = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    for (int k = 0; k < NB; k++) begin
      rd(a_of(k, 0), r); chk(r == 8'h00, "R1 data reset", r, 0);
      rd(a_of(k, 1), r); chk(r == 8'h00, "R1 cfg reset", r, 0);
    end
    rd(OUTA, r); chk(r == 8'hFF, "R5 out reg after reset", r, 8'hFF);

    // full decode sweep R2 R3 R7 R8 R11
    for (int k = 0; k < NB; k++) begin
      for (int ci = 0; ci < 5; ci++) begin
        wr(a_of(k, 1), cfgs[ci]);
        for (int d = 0; d < 256; d++) begin
          wd_err = d[0]; osc_clk = d[3];
          wr(a_of(k, 0), 8'(d));
          #1;
          eoe = '0; eout = '0; epu = '0;
          for (int kk = 0; kk < NB; kk++) begin
            for (int b = 0; b < 8; b++) begin
              logic [2:0] e;
              if (kk == k) e = exp_pad(kk, b, cfgs[ci][b], d[b], wd_err, osc_clk);
              else         e = 3'b000;
              if (kk != k && kk == NB - 1 && b == 1) e = {1'b1, wd_err, 1'b0};
              if (kk != k && kk == NB - 1 && b == 7) e = {1'b0, osc_clk, 1'b0};
              eoe[kk*8+b] = e[2]; eout[kk*8+b] = e[1]; epu[kk*8+b] = e[0];
            end
          end
          chk(bd_pin_oe[k*8 +: 8] == eoe[k*8 +: 8], "R2 R7 R8 oe", bd_pin_oe[k*8 +: 8], eoe[k*8 +: 8]);
          chk(bd_pin_pu[k*8 +: 8] == epu[k*8 +: 8], "R3 R8 pull-up", bd_pin_pu[k*8 +: 8], epu[k*8 +: 8]);
          chk((bd_pin_out[k*8 +: 8] & eoe[k*8 +: 8]) == (eout[k*8 +: 8] & eoe[k*8 +: 8]),
              "R2 R7 R8 out", bd_pin_out[k*8 +: 8], eout[k*8 +: 8]);
          if (d % 37 == 0) begin
            rd(a_of(k, 0), r); chk(r == 8'(d), "R11 data readback", r, d);
            rd(a_of(k, 1), r); chk(r == cfgs[ci], "R11 cfg readback", r, cfgs[ci]);
          end
        end
        wr(a_of(k, 0), 8'h00);
      end
      wr(a_of(k, 1), 8'h00);
    end

    // pin sampling R4
    prev = 8'h00;
    @(negedge clk);
    bd_pin_in = '0;
    @(negedge clk);
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      bd_pin_in[8 +: 8] = 8'(v); bd_pin_in[0 +: 8] = ~8'(v);
      bus_addr = a_of(1, 2);
      #1 chk(bus_rdata == prev, "R4 pin not yet sampled", bus_rdata, prev);
      rd(a_of(1, 2), r); chk(r == 8'(v), "R4 pin read port1", r, v);
      rd(a_of(0, 2), r); chk(r == ~8'(v), "R4 pin read port0", r, ~8'(v));
      prev = 8'(v);
    end

    // output-only port lag R6
    prev = 8'hFF;
    for (int v = 0; v < 256; v += 17) begin
      wr(OUTA, 8'(v));
      bus_addr = OUTA;
      #1;
      chk(bus_rdata == 8'(v), "R6 out reg readback", bus_rdata, v);
      chk(out_pins == prev, "R6 pins still old", out_pins, prev);
      @(negedge clk); #1;
      chk(out_pins == 8'(v), "R6 pins one edge later", out_pins, v);
      prev = 8'(v);
    end

    // input-only port R9
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      in_pins = 8'(v); bus_addr = INA;
      #1 chk(bus_rdata == (8'(v) & INMASK), "R9 input read", bus_rdata, 8'(v) & INMASK);
    end

    // ignored writes and unmapped reads R10
    for (int k = 0; k < NB; k++) begin
      wr(a_of(k, 0), 8'h11 * 8'(k + 1));
      wr(a_of(k, 1), 8'h0C + 8'(k));
    end
    wr(OUTA, 8'h5C);
    for (int a = 0; a < 256; a++) begin
      if (!is_mapped(8'(a)) || a == INA || (a >= BASE && a < BASE + NB * 4 && (a - BASE) % 4 == 2))
        wr(8'(a), 8'hFF);
      if (!is_mapped(8'(a))) begin
        rd(8'(a), r); chk(r == 8'h00, "R10 unmapped read", r, 0);
      end
    end
    for (int k = 0; k < NB; k++) begin
      rd(a_of(k, 0), r); chk(r == 8'h11 * 8'(k + 1), "R10 data untouched", r, 8'h11 * 8'(k + 1));
      rd(a_of(k, 1), r); chk(r == 8'h0C + 8'(k), "R10 cfg untouched", r, 8'h0C + 8'(k));
    end
    rd(OUTA, r); chk(r == 8'h5C, "R10 out untouched", r, 8'h5C);
    @(negedge clk); #1;
    chk(out_pins == 8'h5C, "R9 R10 out pins untouched", out_pins, 8'h5C);

    // asynchronous preset mid-run R5 R1
    #2 rst_n = 1'b0;
    #1 chk(out_pins == 8'hFF, "R5 async preset", out_pins, 8'hFF);
    chk(bd_pin_oe == 24'h020000, "R1 oe after mid-run reset", bd_pin_oe, 24'h020000);
    @(negedge clk); rst_n = 1'b1;
    rd(a_of(0, 0), r); chk(r == 8'h00, "R1 data cleared", r, 0);
    rd(OUTA, r); chk(r == 8'hFF, "R5 out reg preset", r, 8'hFF);

    finished = 1;
    finish_test();
  end

endmodule